// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 131,072 bytes. A requester offers one read or one write at a time with a valid/ready handshake, giving a 17-bit word address and, for writes, one byte of data. The controller then drives the memory's active-low chip select, write enable and output enable, presents the address, and drives or releases the shared data lines. A read returns its byte together with a one-cycle valid strobe.

All memory timing comes from parameters given in nanoseconds together with the clock period. At elaboration each interval is turned into a whole number of cycles, rounded up, and any nonzero interval takes at least one cycle. Output enable stays high for every write, so the shorter write-pulse rule always applies. Chip select and write enable fall on the same edge, so the memory never drives the bus while a write is in progress. The controller releases its data drivers at least one cycle before it lowers output enable, so the memory's drivers and its own never overlap.

Default timing, with a 4 ns clock: a read holds the memory for A = 3 cycles, and a write pulse lasts W = 2 cycles. After a read the idle tail is 2 cycles, and after a write it is 1 cycle.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, req_ready is 1, mem_cs_n, mem_we_n and mem_oe_n are 1, and mem_dq_oe and rd_valid are 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. For a read (req_write=0), the edge presents the address with mem_cs_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0.
- R3: A read captures mem_dq_in on edge A after acceptance, with A = ceil(max(t_aa, t_oe)/t_clk). On that same edge rd_data takes the byte, rd_valid goes high for exactly one cycle, and mem_cs_n and mem_oe_n return to 1.
- R4: A write (req_write=1) lowers mem_cs_n and mem_we_n together on the acceptance edge, and drives req_wdata with mem_dq_oe=1. mem_oe_n stays 1 throughout, and mem_we_n is never low while mem_cs_n is high.
- R5: The write pulse lasts W = ceil(max(t_wp, t_dw, t_aw)/t_clk) cycles. After that, mem_cs_n and mem_we_n rise on the same edge, and the write data stays driven for one more cycle.
- R6: req_ready falls on the acceptance edge. It rises A + max(1, ceil(t_ohz/t_clk), ceil(t_rc/t_clk) - A) edges after a read, and W + max(1, ceil(t_wc/t_clk) - W) edges after a write.
- R7: mem_dq_oe=1 never coincides with mem_oe_n=0, and mem_dq_oe is 0 in the cycle before any fall of mem_oe_n.
- R8: req_valid raised while req_ready is 0 has no effect: the address, strobes and memory contents stay as they are.
- R9: mem_addr is stable for as long as mem_cs_n stays low.
- R10: rd_data holds the last byte read until the next read completes. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle strobe: rd_data has new read data |
| rd_data | output | 8 | Last byte read |
| mem_addr | output | 17 | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data lines |
| mem_dq_oe | output | 1 | 1 = controller drives the data lines |
| mem_dq_in | input | 8 | Byte sampled from the data lines |

## Verification
The bench runs several access patterns:
- Isolated writes followed by reads, which separate the data path from the sequencing.
- Writes and reads at the lowest and highest addresses with bytes 00, FF and A5, which expose address and data bit errors.
- Alternating write/read pairs to one address, which stress the bus turnaround between the memory's drivers and the controller's.
- Back-to-back reads, and a request held high while the controller is busy, which show whether the ready timing and the ignoring of requests are exact.

A cycle-level model predicts every strobe, the ready output and the read data. Separately, a memory model measures each write pulse and flags any overlap of the two sets of drivers.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_TAIL
  } ctrl_state_e;

  // Nanoseconds to whole cycles, rounded up; zero stays zero.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    if (ns <= 0) return 0;
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic              dvalid,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dvalid <= 1'b0;
      dout   <= '0;
    end else begin
      dvalid <= capture;
      if (capture) dout <= din;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 4,
  parameter int T_AA_NS   = 12,
  parameter int T_OE_NS   = 6,
  parameter int T_RC_NS   = 12,
  parameter int T_WC_NS   = 12,
  parameter int T_WP_NS   = 8,
  parameter int T_DW_NS   = 6,
  parameter int T_AW_NS   = 8,
  parameter int T_OHZ_NS  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // Cycle counts derived from the nanosecond parameters.
  localparam int RD_LEN  = imax(1, ns_to_cyc(imax(T_AA_NS, T_OE_NS), CLK_NS));
  localparam int WR_LEN  = imax(1, ns_to_cyc(imax(T_WP_NS, imax(T_DW_NS, T_AW_NS)), CLK_NS));
  localparam int RD_TAIL = imax(1, imax(ns_to_cyc(T_OHZ_NS, CLK_NS),
                                        ns_to_cyc(T_RC_NS, CLK_NS) - RD_LEN));
  localparam int WR_TAIL = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - WR_LEN);
  localparam int CNT_MAX = imax(imax(RD_LEN, WR_LEN), imax(RD_TAIL, WR_TAIL));
  localparam int CNT_W   = imax(1, $clog2(CNT_MAX + 1));

  ctrl_state_e      state;
  logic             is_wr;
  logic             tmr_zero;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             accept;
  logic             access_done;

  assign accept      = (state == ST_IDLE) && req_valid;
  assign access_done = (state == ST_ACCESS) && tmr_zero;
  assign tmr_load    = accept || access_done;

  always_comb begin
    if (accept) begin
      tmr_val = req_write ? CNT_W'(WR_LEN - 1) : CNT_W'(RD_LEN - 1);
    end else begin
      tmr_val = is_wr ? CNT_W'(WR_TAIL - 1) : CNT_W'(RD_TAIL - 1);
    end
  end

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_ctrl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk     (clk),
    .rst     (rst),
    .capture (access_done && !is_wr),
    .din     (mem_dq_in),
    .dvalid  (rd_valid),
    .dout    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      is_wr      <= 1'b0;
      req_ready  <= 1'b1;
      mem_addr   <= '0;
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state     <= ST_ACCESS;
            req_ready <= 1'b0;
            is_wr     <= req_write;
            mem_addr  <= req_addr;
            mem_cs_n  <= 1'b0;
            if (req_write) begin
              mem_we_n   <= 1'b0;
              mem_dq_out <= req_wdata;
              mem_dq_oe  <= 1'b1;
            end else begin
              mem_oe_n <= 1'b0;
            end
          end
        end
        ST_ACCESS: begin
          if (tmr_zero) begin
            state    <= ST_TAIL;
            mem_cs_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_oe_n <= 1'b1;
          end
        end
        ST_TAIL: begin
          mem_dq_oe <= 1'b0;
          if (tmr_zero) begin
            state     <= ST_IDLE;
            req_ready <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n)); // R7

  AST_DQ_RELEASED_BEFORE_OE: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R7

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n)); // R4

  AST_WRITE_ENDS_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> $rose(mem_cs_n)); // R5

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr)); // R9

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R3

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!mem_cs_n && !req_ready)); // R2

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  localparam int TCLK = 4;
  // Expected cycle counts, worked out from the requirement formulas.
  localparam int A  = (12 + TCLK - 1) / TCLK;        // max(12,6) ns
  localparam int W  = (8 + TCLK - 1) / TCLK;         // max(8,6,8) ns
  localparam int RT = 2;                             // max(1, ceil(6/4), 3-3)
  localparam int WT = 1;                             // max(1, 3-2)

  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rd_data, mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;
  logic [16:0] mem_addr;

  always #(TCLK/2) clk = ~clk;

  sram_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] init_byte(input logic [16:0] a);
    return a[7:0] ^ {a[16:13], a[12:9]} ^ 8'h3C;
  endfunction

  // Device side (pins) and reference side (requests) kept apart.
  logic [7:0] dev_mem [int];
  logic [7:0] ref_mem [int];

  function automatic logic [7:0] dev_rd(input logic [16:0] a);
    return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : init_byte(a);
  endfunction
  function automatic logic [7:0] ref_rd(input logic [16:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_byte(a);
  endfunction

  // Memory model: commits a write when it ends, measures the pulse, drives reads.
  int          wlen = 0;
  logic [16:0] waddr;
  logic [7:0]  wdat;
  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_cs_n && !mem_we_n) begin
        wlen++; waddr = mem_addr; wdat = mem_dq_out;
        chk(mem_dq_oe && mem_oe_n, "R4 write drive", {mem_dq_oe, mem_oe_n}, 2'b11);
      end else if (wlen > 0) begin
        chk(wlen * TCLK >= 8, "R5 pulse ns", wlen * TCLK, 8);
        dev_mem[int'(waddr)] = wdat;
        wlen = 0;
      end
      chk(!(mem_dq_oe && !mem_oe_n), "R7 contention", {mem_dq_oe, mem_oe_n}, 2'b01);
    end
    mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ? dev_rd(mem_addr) : 8'hEE;
  end

  // Cycle-level reference model, advanced at each rising edge.
  bit          m_ok = 0, busy = 0, m_wr = 0;
  int          d = 0;
  logic [16:0] m_a = '0;
  logic [7:0]  m_d = '0;
  bit          e_ready = 1, e_cs = 1, e_we = 1, e_oe = 1, e_dqoe = 0, e_rv = 0;
  logic [7:0]  e_rd = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_ok = 1; busy = 0; e_ready = 1; e_cs = 1; e_we = 1; e_oe = 1;
      e_dqoe = 0; e_rv = 0; e_rd = '0;
    end else if (m_ok) begin
      if (!busy) begin
        if (e_ready && req_valid) begin
          busy = 1; d = 0; m_wr = req_write; m_a = req_addr; m_d = req_wdata;
          if (m_wr) ref_mem[int'(m_a)] = m_d;
        end
      end else d++;
      e_rv = 0;
      if (!busy) begin
        e_cs = 1; e_we = 1; e_oe = 1; e_dqoe = 0; e_ready = 1;
      end else if (m_wr) begin
        e_cs = !(d < W); e_we = e_cs; e_oe = 1; e_dqoe = (d <= W);
        e_ready = (d >= W + WT);
      end else begin
        e_cs = !(d < A); e_oe = e_cs; e_we = 1; e_dqoe = 0;
        e_rv = (d == A);
        if (d == A) e_rd = ref_rd(m_a);
        e_ready = (d >= A + RT);
      end
      if (busy && e_ready) busy = 0;
    end
  end

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (m_ok && !rst) begin
      chk(req_ready == e_ready, "R6 ready", req_ready, e_ready);
      chk(mem_cs_n == e_cs, "R2 cs_n", mem_cs_n, e_cs);
      chk(mem_we_n == e_we, "R4 we_n", mem_we_n, e_we);
      chk(mem_oe_n == e_oe, "R2 oe_n", mem_oe_n, e_oe);
      chk(mem_dq_oe == e_dqoe, "R5 dq_oe", mem_dq_oe, e_dqoe);
      chk(rd_valid == e_rv, "R3 rd_valid", rd_valid, e_rv);
      chk(rd_data == e_rd, "R10 rd_data", rd_data, e_rd);
      if (!e_cs) chk(mem_addr == m_a, "R9 addr", mem_addr, m_a);
      if (e_dqoe) chk(mem_dq_out == m_d, "R5 wdata", mem_dq_out, m_d);
    end
  end

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic issue(input logic w, input logic [16:0] a, input logic [7:0] v);
    req_write = w; req_addr = a; req_wdata = v; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
        "R1 in reset", {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid}, 6'b111100);
    rst = 0;
    @(negedge clk);
    chk(req_ready && mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
        "R1 after reset", {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid}, 6'b111100);

    issue(1, 17'h00000, 8'hA5);
    issue(1, 17'h1FFFF, 8'h00);
    issue(1, 17'h01234, 8'hFF);
    issue(0, 17'h00000, 8'h00);
    issue(0, 17'h1FFFF, 8'h00);
    issue(0, 17'h01234, 8'h00);
    issue(0, 17'h00777, 8'h00);
    for (int i = 0; i < 4; i++) begin
      issue(1, 17'h00055, 8'(i * 37 + 1));
      issue(0, 17'h00055, 8'h00);
    end

    // R8: a request held while busy must change nothing.
    issue(1, 17'h00100, 8'h5A);
    req_valid = 1; req_write = 1; req_addr = 17'h00200; req_wdata = 8'hC3;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(mem_addr == 17'h00100 && !req_ready, "R8 busy ignore", mem_addr, 17'h00100);
    end
    req_valid = 0;
    issue(0, 17'h00200, 8'h00);
    issue(0, 17'h00100, 8'h00);
    repeat (8) @(negedge clk);
    chk(dev_rd(17'h00200) == init_byte(17'h00200), "R8 memory untouched",
        dev_rd(17'h00200), init_byte(17'h00200));
    chk(rd_data == 8'h5A, "R10 held after idle", rd_data, 8'h5A);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule